// File: doc/BRIEF.md
# Debug Port Power-Up Sequencer

This controller brings a debug port out of power-down when `start` is pulsed. It drives register accesses through a request/response port. It selects register bank 0 and reads the control/status register. If both power acknowledge bits are already set, it stops there. Otherwise it requests debug and system power, then polls until both acknowledges appear. Next it requests a debug reset and polls for that acknowledge as well. It finishes with a transfer-mode initialisation that depends on the protocol: one write for JTAG, or a write plus a sticky-error clear through the abort register for SWD.

Both polls are bounded by timeouts counted in microsecond ticks. If the power poll expires, the sequence aborts with an error. If the reset poll expires, the controller only raises a warning and continues, which allows a debug reset line that is not connected.

Request rules: `req_valid` rises with `req_write`, `req_addr` and `req_wdata`. All four stay unchanged until a cycle in which `req_ready` is high, and a request is taken in that cycle. `req_ready` may stay low for any number of cycles. Only one access is in flight at a time. After a request is taken, the responder returns a one-cycle `rsp_valid` pulse no earlier than the next cycle. That pulse carries `rsp_rdata`, which is ignored for writes. There is no response back-pressure.

Top module: `dbg_pwrup_ctrl`

## Requirements
- R1: After reset, `done`, `err`, `rst_tmo_warn` and `req_valid` are all 0.
- R2: The first access of every sequence writes 0x00000000 to address 0x8.
- R3: The second access reads address 0x4. If bits 31 and 29 of the returned data are both 1, the sequence ends with `done`=1, `err`=0 and no further accesses.
- R4: Otherwise the controller writes 0x50000000 to address 0x4. It then re-reads address 0x4, one read per response, until bits 31 and 29 are both set.
- R5: If the power poll sees no acknowledge once PWR_TMO_US ticks have elapsed since the poll began, the controller sets `err`=1 and `done`=1 and issues no further accesses. `err` is never 1 without `done`.
- R6: After the power acknowledge, the controller writes 0x54000000 to address 0x4. It then re-reads address 0x4 until bits 31, 29 and 27 are all set.
- R7: If the reset poll expires after RST_TMO_US ticks, the controller sets `rst_tmo_warn`=1, leaves `err`=0 and continues to the final step. The warning and the error are never both set.
- R8: With `proto_swd`=0 (JTAG), the last access writes 0x50000F32 to address 0x4.
- R9: With `proto_swd`=1 (SWD), the controller writes 0x50000F00 to address 0x4, then writes 0x0000001E to address 0x0 as the last access.
- R10: While `req_valid`=1 and `req_ready`=0, the request fields hold. No new request is raised between acceptance and `rsp_valid`. Every request targets address 0x0, 0x4 or 0x8.
- R11: `start` and `proto_swd` are ignored while a sequence runs. `done`, `err` and `rst_tmo_warn` hold after completion until the next `start`, which clears them. No access is raised while `done`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (idle or finished only) |
| proto_swd | input | 1 | 0 = JTAG final step, 1 = SWD final steps; sampled at start |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register request taken |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Register address |
| req_wdata | output | DATA_W | Write data |
| rsp_valid | input | 1 | One-cycle response strobe |
| rsp_rdata | input | DATA_W | Read data with the response |
| done | output | 1 | Sequence finished |
| err | output | 1 | Power acknowledge timed out |
| rst_tmo_warn | output | 1 | Debug-reset acknowledge timed out (non-fatal) |

## Verification
The following are checked on every cycle:
- request stability under back-pressure;
- the single-outstanding rule;
- legal addresses;
- silence while `done` is set;
- the pairing of `err` with `done`;
- the exclusion between warning and error.

The ordered list of writes and data values for each protocol can only be shown by the bench's scenarios. The same holds for the number of poll reads, the skip when the port is already powered, both timeout outcomes, and the clearing of the status flags on restart.

// File: rtl/dpu_pkg.sv
package dpu_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_CHK, ST_PWR_REQ, ST_PWR_POLL,
    ST_RST_REQ, ST_RST_POLL, ST_INIT, ST_ABORT, ST_FIN
  } dpu_state_e;

  localparam int unsigned ADR_ABORT = 0;
  localparam int unsigned ADR_STAT  = 4;
  localparam int unsigned ADR_BANK  = 8;

  localparam logic [31:0] VAL_BANK0    = 32'h0000_0000;
  localparam logic [31:0] VAL_PWR_REQ  = 32'h5000_0000;
  localparam logic [31:0] VAL_RST_REQ  = 32'h5400_0000;
  localparam logic [31:0] VAL_INIT_JT  = 32'h5000_0F32;
  localparam logic [31:0] VAL_INIT_SW  = 32'h5000_0F00;
  localparam logic [31:0] VAL_ABORT    = 32'h0000_001E;
  localparam logic [31:0] MSK_PWR_ACK  = 32'hA000_0000;
  localparam logic [31:0] MSK_RST_ACK  = 32'hA800_0000;

  localparam int TMO_PWR = 0;
  localparam int TMO_RST = 1;
  localparam int N_TMO   = 2;
endpackage

// File: rtl/dpu_tmo.sv
module dpu_tmo #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expired = (cnt >= CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clear)           cnt <= '0;
    else if (tick && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dpu_reg_port.sv
module dpu_reg_port #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_done,
  output logic [DATA_W-1:0] cmd_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata
);
  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT} ph_e;
  ph_e ph;

  assign req_valid = (ph == PH_REQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      cmd_done  <= 1'b0;
      cmd_rdata <= '0;
    end else begin
      cmd_done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (cmd_go) begin
          ph        <= PH_REQ;
          req_write <= cmd_write;
          req_addr  <= cmd_addr;
          req_wdata <= cmd_wdata;
        end
        PH_REQ:  if (req_ready) ph <= PH_WAIT;
        PH_WAIT: if (rsp_valid) begin
          ph        <= PH_IDLE;
          cmd_done  <= 1'b1;
          cmd_rdata <= rsp_rdata;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dpu_seq.sv
module dpu_seq
  import dpu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              proto_swd,
  input  logic              cmd_done,
  input  logic [DATA_W-1:0] cmd_rdata,
  input  logic [N_TMO-1:0]  tmo_exp,
  output logic              cmd_go,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  output logic [N_TMO-1:0]  tmo_clr,
  output logic              done,
  output logic              err,
  output logic              warn
);
  dpu_state_e state, nxt;
  logic pend, swd_q, is_acc, pwr_ack, rst_ack, set_err, set_warn;

  assign pwr_ack = (cmd_rdata & DATA_W'(MSK_PWR_ACK)) == DATA_W'(MSK_PWR_ACK);
  assign rst_ack = (cmd_rdata & DATA_W'(MSK_RST_ACK)) == DATA_W'(MSK_RST_ACK);
  assign is_acc  = (state != ST_IDLE) && (state != ST_FIN);
  assign cmd_go  = is_acc && !pend;

  // Access descriptor for the current step
  always_comb begin
    cmd_write = 1'b1;
    cmd_addr  = ADDR_W'(ADR_STAT);
    cmd_wdata = '0;
    unique case (state)
      ST_SEL:      begin cmd_addr = ADDR_W'(ADR_BANK); cmd_wdata = DATA_W'(VAL_BANK0); end
      ST_PWR_REQ:  cmd_wdata = DATA_W'(VAL_PWR_REQ);
      ST_RST_REQ:  cmd_wdata = DATA_W'(VAL_RST_REQ);
      ST_INIT:     cmd_wdata = swd_q ? DATA_W'(VAL_INIT_SW) : DATA_W'(VAL_INIT_JT);
      ST_ABORT:    begin cmd_addr = ADDR_W'(ADR_ABORT); cmd_wdata = DATA_W'(VAL_ABORT); end
      ST_CHK, ST_PWR_POLL, ST_RST_POLL: cmd_write = 1'b0;
      default: ;
    endcase
  end

  // Step sequencing on each completed access
  always_comb begin
    nxt      = state;
    set_err  = 1'b0;
    set_warn = 1'b0;
    tmo_clr  = '0;
    if (cmd_done) begin
      unique case (state)
        ST_SEL:      nxt = ST_CHK;
        ST_CHK:      nxt = pwr_ack ? ST_FIN : ST_PWR_REQ;
        ST_PWR_REQ:  begin nxt = ST_PWR_POLL; tmo_clr[TMO_PWR] = 1'b1; end
        ST_PWR_POLL: begin
          if (pwr_ack)                   nxt = ST_RST_REQ;
          else if (tmo_exp[TMO_PWR]) begin nxt = ST_FIN; set_err = 1'b1; end
        end
        ST_RST_REQ:  begin nxt = ST_RST_POLL; tmo_clr[TMO_RST] = 1'b1; end
        ST_RST_POLL: begin
          if (rst_ack)                   nxt = ST_INIT;
          else if (tmo_exp[TMO_RST]) begin nxt = ST_INIT; set_warn = 1'b1; end
        end
        ST_INIT:     nxt = swd_q ? ST_ABORT : ST_FIN;
        ST_ABORT:    nxt = ST_FIN;
        default:     nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
      swd_q <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      warn  <= 1'b0;
    end else if (!is_acc) begin
      if (start) begin
        state <= ST_SEL;
        swd_q <= proto_swd;
        done  <= 1'b0;
        err   <= 1'b0;
        warn  <= 1'b0;
      end
    end else begin
      if (cmd_go) pend <= 1'b1;
      if (cmd_done) begin
        pend  <= 1'b0;
        state <= nxt;
        if (nxt == ST_FIN) done <= 1'b1;
        if (set_err)  err  <= 1'b1;
        if (set_warn) warn <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_pwrup_ctrl.sv
module dbg_pwrup_ctrl
  import dpu_pkg::*;
#(
  parameter int          ADDR_W     = 4,
  parameter int          DATA_W     = 32,
  parameter int unsigned PWR_TMO_US = 1000000,
  parameter int unsigned RST_TMO_US = 300000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              proto_swd,
  input  logic              us_tick,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              done,
  output logic              err,
  output logic              rst_tmo_warn
);
  logic              cmd_go, cmd_write, cmd_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata, cmd_rdata;
  logic [N_TMO-1:0]  tmo_clr, tmo_exp;

  dpu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .proto_swd(proto_swd),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .tmo_exp(tmo_exp),
    .cmd_go(cmd_go), .cmd_write(cmd_write), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .tmo_clr(tmo_clr),
    .done(done), .err(err), .warn(rst_tmo_warn)
  );

  dpu_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
    .cmd_rdata(cmd_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  for (genvar g = 0; g < N_TMO; g++) begin : g_tmo
    localparam int unsigned LIM = (g == TMO_PWR) ? PWR_TMO_US : RST_TMO_US;
    dpu_tmo #(.LIMIT(LIM)) u_tmo (
      .clk(clk), .rst_n(rst_n), .clear(tmo_clr[g]),
      .tick(us_tick), .expired(tmo_exp[g])
    );
  end
endmodule

// File: rtl/dpu_checker.sv
module dpu_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              done,
  input logic              err,
  input logic              rst_tmo_warn
);
  logic in_flight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      in_flight <= 1'b0;
    else if (req_valid && req_ready) in_flight <= 1'b1;
    else if (rsp_valid)              in_flight <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_wdata) && $stable(req_write)); // R10
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !req_valid); // R10
  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr == ADDR_W'(0) || req_addr == ADDR_W'(4) ||
                   req_addr == ADDR_W'(8))); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid); // R11
  AST_ERR_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R5
  AST_WARN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && rst_tmo_warn)); // R7
endmodule

bind dbg_pwrup_ctrl dpu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .done(done), .err(err), .rst_tmo_warn(rst_tmo_warn)
);

// File: tb/dbg_pwrup_ctrl_bench.sv
module dbg_pwrup_ctrl_bench;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int PT = 20;
  localparam int RT = 10;
  localparam int NEVER = 1000000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, proto_swd = 1'b0, us_tick = 1'b0;
  logic req_valid, req_ready = 1'b0, req_write, rsp_valid = 1'b0;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_rdata = '0;
  logic done, err, rst_tmo_warn;

  always #4 clk = ~clk;

  dbg_pwrup_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PWR_TMO_US(PT), .RST_TMO_US(RT))
  u_dbg_pwrup_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .proto_swd(proto_swd),
    .us_tick(us_tick), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .done(done), .err(err),
    .rst_tmo_warn(rst_tmo_warn)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [AW-1:0] w_addr [16];
  logic [DW-1:0] w_data [16];
  int n_wr, n_rd, tick_cnt;
  bit pwr_init, bp, pwr_seen, rst_seen;
  int pwr_delay, rst_delay, pwr_reads, rst_reads;

  // Register responder: accepts, answers on the following cycle
  initial begin
    bit pending = 0, due = 0, phase = 0, rdy;
    logic [DW-1:0] hold = '0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (due) begin
        rsp_valid = 1'b1; rsp_rdata = hold; due = 0; pending = 0;
      end
      rdy = !pending && (!bp || phase);
      req_ready = rdy;
      phase = ~phase;
      if (req_valid && rdy) begin
        pending = 1; due = 1; hold = '0;
        if (req_write) begin
          if (n_wr < 16) begin w_addr[n_wr] = req_addr; w_data[n_wr] = req_wdata; end
          n_wr++;
          if (req_addr == 4 && req_wdata == 32'h5000_0000) pwr_seen = 1;
          if (req_addr == 4 && req_wdata == 32'h5400_0000) rst_seen = 1;
        end else begin
          n_rd++;
          if (req_addr == 4) begin
            if (pwr_init || (pwr_seen && pwr_reads >= pwr_delay)) hold |= 32'hA000_0000;
            if (rst_seen && rst_reads >= rst_delay) hold |= 32'h0800_0000;
            if (rst_seen) rst_reads++;
            else if (pwr_seen) pwr_reads++;
          end
        end
      end
    end
  end

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % 4;
      us_tick = (div == 0);
      if (us_tick) tick_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic prep(input bit pi, input int pd, input int rd, input bit b);
    @(negedge clk);
    pwr_init = pi; pwr_delay = pd; rst_delay = rd; bp = b;
    pwr_seen = 0; rst_seen = 0; pwr_reads = 0; rst_reads = 0;
    n_wr = 0; n_rd = 0; tick_cnt = 0;
  endtask

  task automatic pulse_start(input bit p);
    @(negedge clk); proto_swd = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!done && k < 20000) begin @(negedge clk); k++; end
    chk(done === 1'b1, tag, done, 1);
  endtask

  task automatic chk_wr(input int i, input int a, input logic [31:0] d, input string tag);
    chk(w_addr[i] == AW'(a) && w_data[i] == d, tag, w_data[i], d);
  endtask

  task automatic t_reset;
    chk(done === 1'b0, "R1 done", done, 0);
    chk(err === 1'b0, "R1 err", err, 0);
    chk(rst_tmo_warn === 1'b0, "R1 warn", rst_tmo_warn, 0);
    chk(req_valid === 1'b0, "R1 req_valid", req_valid, 0);
  endtask

  task automatic t_powered;
    prep(1, 0, 0, 0);
    pulse_start(0);
    wait_done("R3 done");
    repeat (5) @(negedge clk);
    chk(n_wr == 1, "R2 write count", n_wr, 1);
    chk_wr(0, 8, 32'h0, "R2 bank select");
    chk(n_rd == 1, "R3 single read", n_rd, 1);
    chk(err === 1'b0, "R3 err", err, 0);
  endtask

  task automatic t_jtag_full;
    prep(0, 2, 1, 0);
    pulse_start(0);
    wait_done("R8 done");
    chk(n_wr == 4, "R8 write count", n_wr, 4);
    chk_wr(1, 4, 32'h5000_0000, "R4 power request");
    chk(n_rd == 6, "R4 poll reads", n_rd, 6);
    chk_wr(2, 4, 32'h5400_0000, "R6 reset request");
    chk_wr(3, 4, 32'h5000_0F32, "R8 JTAG init");
    chk(err === 1'b0 && rst_tmo_warn === 1'b0, "R6 flags", {err, rst_tmo_warn}, 0);
  endtask

  task automatic t_swd_bp;
    prep(0, 1, 0, 1);
    pulse_start(1);
    wait_done("R10 done under back-pressure");
    chk(n_wr == 5, "R9 write count", n_wr, 5);
    chk_wr(0, 8, 32'h0, "R10 bank select");
    chk_wr(3, 4, 32'h5000_0F00, "R9 SWD init");
    chk_wr(4, 0, 32'h0000_001E, "R9 abort clear");
    chk(n_rd == 4, "R10 read count", n_rd, 4);
  endtask

  task automatic t_pwr_timeout;
    prep(0, NEVER, 0, 0);
    pulse_start(0);
    wait_done("R5 done");
    chk(err === 1'b1, "R5 err", err, 1);
    chk(tick_cnt >= PT, "R5 ticks elapsed", tick_cnt, PT);
    repeat (30) @(negedge clk);
    chk(n_wr == 2, "R5 no writes after error", n_wr, 2);
    chk(err === 1'b1 && done === 1'b1, "R11 flags held", {err, done}, 3);
  endtask

  task automatic t_restart_clears;
    prep(1, 0, 0, 0);
    pulse_start(0);
    chk(done === 1'b0 && err === 1'b0, "R11 start clears", {done, err}, 0);
    wait_done("R11 rerun done");
    chk(err === 1'b0, "R11 rerun err", err, 0);
  endtask

  task automatic t_rst_timeout;
    prep(0, 0, NEVER, 0);
    pulse_start(1);
    wait_done("R7 done");
    chk(rst_tmo_warn === 1'b1, "R7 warn", rst_tmo_warn, 1);
    chk(err === 1'b0, "R7 err", err, 0);
    chk(n_wr == 5, "R7 continues", n_wr, 5);
    chk_wr(4, 0, 32'h0000_001E, "R7 final abort");
  endtask

  task automatic t_start_busy;
    prep(0, 2, 1, 0);
    pulse_start(0);
    repeat (6) @(negedge clk);
    proto_swd = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done("R11 busy done");
    chk(n_wr == 4, "R11 busy write count", n_wr, 4);
    chk_wr(3, 4, 32'h5000_0F32, "R11 protocol kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_powered();
    t_jtag_full();
    t_swd_bp();
    t_pwr_timeout();
    t_restart_clears();
    t_rst_timeout();
    t_start_busy();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog act=%0h exp=%0h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule